// File: doc/BRIEF.md
# Reset-Aware Configurable Port Controller

This block controls one general-purpose I/O port of `W` pins. It takes an active-low external reset and filters it: a low level that lasts fewer than `MIN_LOW` clocks is ignored. A longer low level puts the block into an internal reset. That reset stays active for `STRETCH` further clocks after the external input is released, and the same stretched reset is given to the rest of the chip as `sys_rst_n`. While the internal reset is active, the configuration bank is cleared. The bank holds six registers: mode control, two function-select planes, output data, direction and open-drain enable. A plain write/read bus reaches the bank.

Each pin belongs to one of five classes. Pins set in the build-time mask `LOGIC_MASK` are always logic-array outputs. Every other pin is an address output, plain port I/O, data-port pin or peripheral pin, as the registers select. For each pin the block decides every cycle whether to drive the pad, release it or hold the last value. That choice depends on the class, the internal reset and the standby request. In standby, plain port pins keep the state they had in the last cycle before standby.

Top module: `gpio_port_ctl`

## Requirements
- R1: `rst_n` passes through a two-flop synchroniser. When the synchronised level has been low for `MIN_LOW` consecutive clocks, the internal reset starts and `sys_rst_n` goes low.
- R2: A low pulse on `rst_n` that is sampled on fewer than `MIN_LOW` clock edges has no effect: `sys_rst_n` stays high and register contents are kept.
- R3: `sys_rst_n` rises on the (`STRETCH`+3)-th rising clock edge, counting the first edge that samples `rst_n` high as the first. Any low sample that reaches the synchroniser output while the internal reset is active restarts this count.
- R4: While `sys_rst_n` is low, reads return zero and writes are lost. Every register reads zero when the internal reset ends.
- R5: The register map is: address 0 mode control, 1 select plane A, 2 select plane B, 3 output data, 4 direction, 5 open-drain. Addresses 6 and 7 read zero and ignore writes. A write with `bus_wr` high takes effect on the next rising edge. `bus_rdata` is a combinational function of `bus_addr`.
- R6: Pin class decode. A pin in `LOGIC_MASK` is a logic-array output. Otherwise, a mode bit of 0 makes the pin an address output. A mode bit of 1 uses {plane B, plane A}: 01 gives data port, 10 gives peripheral, and 00 or 11 gives plain port I/O.
- R7: A plain port pin outside standby behaves as follows. With direction 0 its enable is 0. With direction 1 and open-drain 0 it drives the data bit. With direction 1 and open-drain 1 it drives 0 only when the data bit is 0, and otherwise releases the pad.
- R8: Outside reset and standby, address pins drive `addr_in` and logic pins drive `logic_in`, both enabled. Data pins drive `data_in` with enable `data_oe_in`. Peripheral pins drive `periph_in` with enable `periph_oe_in`.
- R9: While `sys_rst_n` is low, every pin outside `LOGIC_MASK` has enable 0 and output 0. Logic pins keep driving `logic_in`.
- R10: In standby, plain port pins hold the output and enable they had in the last cycle before standby, even if `logic_in` or the registers change. Data and peripheral pins are released, logic pins follow `logic_in`, and address pins are enabled with a fixed level.
- R11: The internal reset takes precedence over standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External active-low reset, asynchronous to clk |
| standby | input | 1 | Standby request |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data |
| addr_in | input | W | Address bits for address-output pins |
| logic_in | input | W | Logic-array outputs |
| data_in | input | W | Data-port output values |
| data_oe_in | input | 1 | Data-port drive enable |
| periph_in | input | W | Peripheral output values |
| periph_oe_in | input | W | Per-pin peripheral drive enable |
| pad_out | output | W | Pad output level |
| pad_oe | output | W | Pad drive enable |
| sys_rst_n | output | 1 | Stretched active-low internal reset |

## Verification
The bench sends a reset pulse one clock shorter than the filter length and expects nothing to happen; a filter that counts one clock short would reset the block and lose the registers. It sends a pulse of exactly the filter length and then times the release to the edge, so an off-by-one in the synchroniser or the stretch count shows up as a wrong latency. A short glitch during the stretch window must restart the count; a design that ignores it releases early. In standby, the bench changes the data register and `logic_in` and expects port pins to stay frozen, and it raises reset during standby to confirm that reset, not the hold, wins.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [2:0] {
    CLS_ADDR   = 3'd0,
    CLS_PORT   = 3'd1,
    CLS_LOGIC  = 3'd2,
    CLS_DATA   = 3'd3,
    CLS_PERIPH = 3'd4
  } pin_cls_e;

  localparam int unsigned NUM_REGS  = 6;
  localparam int unsigned REG_MODE  = 0;
  localparam int unsigned REG_SELA  = 1;
  localparam int unsigned REG_SELB  = 2;
  localparam int unsigned REG_DOUT  = 3;
  localparam int unsigned REG_DIR   = 4;
  localparam int unsigned REG_ODRN  = 5;

  typedef struct packed {
    logic drv;
    logic val;
  } pin_drv_t;

  // Class of one pin from its fixed mask bit and its register bits.
  function automatic pin_cls_e pick_class(input logic fixed_logic, input logic mode,
                                          input logic sel_a, input logic sel_b);
    pin_cls_e c;
    if (fixed_logic)   c = CLS_LOGIC;
    else if (!mode)    c = CLS_ADDR;
    else begin
      unique case ({sel_b, sel_a})
        2'b01:   c = CLS_DATA;
        2'b10:   c = CLS_PERIPH;
        default: c = CLS_PORT;
      endcase
    end
    return c;
  endfunction

  // Plain port drive: push-pull follows data, open-drain only pulls low.
  function automatic pin_drv_t port_drive(input logic dout, input logic dir, input logic odrn);
    pin_drv_t p;
    if (odrn) begin
      p.drv = dir & ~dout;
      p.val = 1'b0;
    end else begin
      p.drv = dir;
      p.val = dout;
    end
    return p;
  endfunction

endpackage

// File: rtl/gpc_rst_stretch.sv
module gpc_rst_stretch #(
  parameter int unsigned STRETCH = 12,
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n_ext,
  output logic sync_lvl,
  output logic accept,
  output logic core_rst
);
  localparam int unsigned SW = $clog2(STRETCH + 1);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);

  logic          meta_q;
  logic          sync_q;
  logic [LW-1:0] low_cnt;
  logic [SW-1:0] hold_cnt;
  logic          in_rst;
  logic          release_evt;

  always_ff @(posedge clk) begin
    meta_q <= rst_n_ext;
    sync_q <= meta_q;
  end

  // Length of the current low run seen after the synchroniser.
  always_ff @(posedge clk) begin
    if (sync_q)                         low_cnt <= '0;
    else if (low_cnt != LW'(MIN_LOW))   low_cnt <= low_cnt + 1'b1;
  end

  assign accept      = !sync_q && (low_cnt >= LW'(MIN_LOW - 1));
  assign release_evt = in_rst && sync_q && (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (accept) begin
      in_rst   <= 1'b1;
      hold_cnt <= SW'(STRETCH);
    end else if (in_rst) begin
      if (!sync_q)          hold_cnt <= SW'(STRETCH);
      else if (release_evt) in_rst   <= 1'b0;
      else                  hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign sync_lvl = sync_q;
  assign core_rst = in_rst;

endmodule

// File: rtl/gpc_cfg_bank.sv
module gpc_cfg_bank
  import gpc_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      mode,
  output logic [W-1:0]      sel_a,
  output logic [W-1:0]      sel_b,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      dir,
  output logic [W-1:0]      odrn
);
  logic [W-1:0] bank [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (clr)                                 bank[r] <= '0;
      else if (wr && addr == ADDR_W'(r))       bank[r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (!clr) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr == ADDR_W'(r)) rdata = bank[r];
    end
  end

  assign mode  = bank[REG_MODE];
  assign sel_a = bank[REG_SELA];
  assign sel_b = bank[REG_SELB];
  assign dout  = bank[REG_DOUT];
  assign dir   = bank[REG_DIR];
  assign odrn  = bank[REG_ODRN];

endmodule

// File: rtl/gpc_pin_policy.sv
module gpc_pin_policy
  import gpc_pkg::*;
#(
  parameter int unsigned    W          = 8,
  parameter logic [W-1:0]   LOGIC_MASK = '0
) (
  input  logic         clk,
  input  logic         core_rst,
  input  logic         standby,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] sel_a,
  input  logic [W-1:0] sel_b,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] odrn,
  input  logic [W-1:0] addr_src,
  input  logic [W-1:0] logic_src,
  input  logic [W-1:0] data_src,
  input  logic         data_en,
  input  logic [W-1:0] per_src,
  input  logic [W-1:0] per_en,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] port_mask,
  output logic [W-1:0] quiet_mask
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pin_cls_e cls;
    pin_drv_t live;
    pin_drv_t held;
    pin_drv_t fin;

    always_comb cls = pick_class(LOGIC_MASK[i], mode[i], sel_a[i], sel_b[i]);

    always_comb begin
      unique case (cls)
        CLS_PORT:   live = port_drive(dout[i], dir[i], odrn[i]);
        CLS_LOGIC:  live = '{drv: 1'b1, val: logic_src[i]};
        CLS_DATA:   live = '{drv: data_en, val: data_src[i]};
        CLS_PERIPH: live = '{drv: per_en[i], val: per_src[i]};
        default:    live = '{drv: 1'b1, val: addr_src[i]};
      endcase
    end

    // Last pre-standby state of this pin.
    always_ff @(posedge clk) begin
      if (core_rst)      held <= '0;
      else if (!standby) held <= live;
    end

    always_comb begin
      if (core_rst) begin
        fin = (cls == CLS_LOGIC) ? live : '0;
      end else if (standby) begin
        unique case (cls)
          CLS_PORT:              fin = held;
          CLS_LOGIC:             fin = live;
          CLS_DATA, CLS_PERIPH:  fin = '0;
          default:               fin = '{drv: 1'b1, val: 1'b0};
        endcase
      end else begin
        fin = live;
      end
    end

    assign pad_out[i]    = fin.val;
    assign pad_oe[i]     = fin.drv;
    assign port_mask[i]  = (cls == CLS_PORT);
    assign quiet_mask[i] = (cls == CLS_DATA) || (cls == CLS_PERIPH);
  end

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpc_pkg::*;
#(
  parameter int unsigned  W          = 8,
  parameter int unsigned  ADDR_W     = 3,
  parameter int unsigned  STRETCH    = 12,
  parameter int unsigned  MIN_LOW    = 4,
  parameter logic [W-1:0] LOGIC_MASK = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      addr_in,
  input  logic [W-1:0]      logic_in,
  input  logic [W-1:0]      data_in,
  input  logic              data_oe_in,
  input  logic [W-1:0]      periph_in,
  input  logic [W-1:0]      periph_oe_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic              sys_rst_n
);
  logic         rst_sync;
  logic         rst_accept;
  logic         core_rst;
  logic [W-1:0] mode, sel_a, sel_b, dout, dir, odrn;
  logic [W-1:0] port_mask;
  logic [W-1:0] quiet_mask;

  gpc_rst_stretch #(.STRETCH(STRETCH), .MIN_LOW(MIN_LOW)) u_rst (
    .clk       (clk),
    .rst_n_ext (rst_n),
    .sync_lvl  (rst_sync),
    .accept    (rst_accept),
    .core_rst  (core_rst)
  );

  gpc_cfg_bank #(.W(W), .ADDR_W(ADDR_W)) u_cfg (
    .clk   (clk),
    .clr   (core_rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .mode  (mode),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .dout  (dout),
    .dir   (dir),
    .odrn  (odrn)
  );

  gpc_pin_policy #(.W(W), .LOGIC_MASK(LOGIC_MASK)) u_pins (
    .clk        (clk),
    .core_rst   (core_rst),
    .standby    (standby),
    .mode       (mode),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .dout       (dout),
    .dir        (dir),
    .odrn       (odrn),
    .addr_src   (addr_in),
    .logic_src  (logic_in),
    .data_src   (data_in),
    .data_en    (data_oe_in),
    .per_src    (periph_in),
    .per_en     (periph_oe_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .port_mask  (port_mask),
    .quiet_mask (quiet_mask)
  );

  assign sys_rst_n = !core_rst;

endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
  parameter int unsigned  W          = 8,
  parameter int unsigned  STRETCH    = 12,
  parameter int unsigned  MIN_LOW    = 4,
  parameter logic [W-1:0] LOGIC_MASK = '0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         standby,
  input logic         sys_rst_n,
  input logic         rst_sync,
  input logic         rst_accept,
  input logic [W-1:0] bus_rdata,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] port_mask,
  input logic [W-1:0] quiet_mask
);
  localparam int unsigned CW   = $clog2(STRETCH + MIN_LOW + 2) + 1;
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] hi_run;
  logic [CW-1:0] lo_run;

  // Independent run-length counters on the synchronised reset level.
  always_ff @(posedge clk) begin
    if (rst_sync) begin
      lo_run <= '0;
      if (hi_run != TOP) hi_run <= hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      if (lo_run != TOP) lo_run <= lo_run + 1'b1;
    end
  end

  // R2 also: a shorter low run can never pull the reset output low.
  assert_min_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_n) |-> (lo_run >= CW'(MIN_LOW)));

  assert_accept_hits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_accept |=> !sys_rst_n);

  assert_stretch_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (hi_run >= CW'(STRETCH + 1)));

  assert_regs_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (bus_rdata == '0));

  assert_reset_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> ((pad_oe & ~LOGIC_MASK) == '0));

  assert_standby_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && $past(sys_rst_n) && standby && $past(standby)) |->
      ((((pad_out ^ $past(pad_out)) | (pad_oe ^ $past(pad_oe))) & port_mask & $past(port_mask)) == '0));

  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && standby) |-> ((pad_oe & quiet_mask) == '0));

endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
  .W(W), .STRETCH(STRETCH), .MIN_LOW(MIN_LOW), .LOGIC_MASK(LOGIC_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .standby    (standby),
  .sys_rst_n  (sys_rst_n),
  .rst_sync   (rst_sync),
  .rst_accept (rst_accept),
  .bus_rdata  (bus_rdata),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .port_mask  (port_mask),
  .quiet_mask (quiet_mask)
);

// File: tb/gpio_port_ctl_test.sv
`timescale 1ns/100ps
module gpio_port_ctl_test;
  localparam int STRETCH = 12;
  localparam int MIN_LOW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] addr_in = 8'hA5, logic_in = 8'h80, data_in = 8'h3C;
  logic       data_oe_in = 1'b1;
  logic [7:0] periph_in = 8'h5A, periph_oe_in = 8'h0F;
  logic [7:0] pad_out, pad_oe;
  logic       sys_rst_n;

  gpio_port_ctl #(.W(8), .ADDR_W(3), .STRETCH(STRETCH), .MIN_LOW(MIN_LOW), .LOGIC_MASK(8'hC0)) uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_in(addr_in), .logic_in(logic_in),
    .data_in(data_in), .data_oe_in(data_oe_in), .periph_in(periph_in),
    .periph_oe_in(periph_oe_in), .pad_out(pad_out), .pad_oe(pad_oe), .sys_rst_n(sys_rst_n));

  always #2.5 clk = ~clk;

  typedef struct {
    string      req;
    int         kind;   // 0 pad_out, 1 pad_oe, 2 bus_rdata
    logic [7:0] exp;
    logic [7:0] mask;
  } item_t;

  item_t q[$];
  event  probe_ev;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  task automatic tally(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against live outputs.
  initial begin
    forever begin
      @(probe_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.kind == 0) ? pad_out : (it.kind == 1) ? pad_oe : bus_rdata;
        tally(it.req, ((act ^ it.exp) & it.mask) == 8'h00, int'(act & it.mask), int'(it.exp & it.mask));
      end
    end
  end

  task automatic fire();
    -> probe_ev;
    #0.2;
  endtask

  task automatic expect_pins(input string req, input logic [7:0] eout, input logic [7:0] omask,
                             input logic [7:0] eoe);
    q.push_back('{req: {req, " pad_out"}, kind: 0, exp: eout, mask: omask});
    q.push_back('{req: {req, " pad_oe"},  kind: 1, exp: eoe,  mask: 8'hFF});
    fire();
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [7:0] e);
    bus_addr = a;
    #0.3;
    q.push_back('{req: req, kind: 2, exp: e, mask: 8'hFF});
    fire();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input int len);
    @(negedge clk) rst_n = 1'b0;
    repeat (len) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called right after rst_n went high on a falling edge.
  task automatic time_release(input string req);
    int n = 0;
    bit seen_low = !sys_rst_n;
    while (!(seen_low && sys_rst_n) && n < 200) begin
      @(negedge clk);
      n++;
      if (!sys_rst_n) seen_low = 1'b1;
    end
    tally({req, " reset seen"}, seen_low, int'(seen_low), 1);
    tally({req, " release latency"}, n == STRETCH + 3, n, STRETCH + 3);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      tally("watchdog", 1'b0, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    #0.5;
    tally("R1 reset accepted", sys_rst_n == 1'b0, int'(sys_rst_n), 0);
    expect_pins("R9 during reset", 8'h80, 8'hFF, 8'hC0);
    expect_rd("R4 read in reset", 3'd0, 8'h00);

    @(negedge clk) rst_n = 1'b1;
    time_release("R3 first");
    for (int a = 0; a < 6; a++) expect_rd("R4 cleared", 3'(a), 8'h00);
    #0.3;
    expect_pins("R6 R8 all address", 8'hA5, 8'hFF, 8'hFF);

    wr(3'd0, 8'h1F); wr(3'd1, 8'h14); wr(3'd2, 8'h18);
    wr(3'd3, 8'h11); wr(3'd4, 8'h13); wr(3'd5, 8'h02);
    wr(3'd6, 8'hFF);
    #0.5;
    expect_rd("R5 mode", 3'd0, 8'h1F);
    expect_rd("R5 sel a", 3'd1, 8'h14);
    expect_rd("R5 sel b", 3'd2, 8'h18);
    expect_rd("R5 dout", 3'd3, 8'h11);
    expect_rd("R5 dir", 3'd4, 8'h13);
    expect_rd("R5 odrn", 3'd5, 8'h02);
    expect_rd("R5 unmapped", 3'd6, 8'h00);
    expect_pins("R6 mixed classes", 8'hBD, 8'hFF, 8'hFF);

    wr(3'd3, 8'h13); wr(3'd4, 8'h12);
    #0.5;
    expect_pins("R7 open drain release and input", 8'hBD, 8'hFF, 8'hFC);
    periph_oe_in = 8'h00; data_oe_in = 1'b0;
    #0.3;
    expect_pins("R8 data/periph enables", 8'hBD, 8'hFF, 8'hF0);
    periph_oe_in = 8'h0F; data_oe_in = 1'b1;

    @(negedge clk) standby = 1'b1;
    logic_in = 8'h40;
    wr(3'd3, 8'h00);
    #0.5;
    expect_pins("R10 standby hold", 8'h51, 8'hDF, 8'hF0);
    @(negedge clk) standby = 1'b0;
    #0.5;
    expect_pins("R10 standby exit", 8'h6C, 8'hFF, 8'hFE);
    expect_rd("R5 write in standby", 3'd3, 8'h00);

    pulse(MIN_LOW - 1);
    begin
      bit stayed = 1'b1;
      repeat (12) begin
        @(negedge clk);
        if (!sys_rst_n) stayed = 1'b0;
      end
      tally("R2 short pulse ignored", stayed, int'(stayed), 1);
    end
    #0.5;
    expect_rd("R2 mode kept", 3'd0, 8'h1F);

    pulse(MIN_LOW);
    time_release("R1 R3 minimum pulse");
    #0.5;
    expect_rd("R4 cleared after min pulse", 3'd0, 8'h00);

    wr(3'd0, 8'h3F); wr(3'd4, 8'h3F); wr(3'd3, 8'h3F);
    #0.5;
    expect_pins("R7 push-pull ports", 8'h7F, 8'hFF, 8'hFF);
    @(negedge clk) standby = 1'b1;
    @(negedge clk) rst_n = 1'b0;
    repeat (8) @(negedge clk);
    #0.5;
    expect_pins("R11 reset over standby", 8'h40, 8'hFF, 8'hC0);
    wr(3'd0, 8'hFF);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pulse(2);
    time_release("R3 restart in stretch");
    @(negedge clk) standby = 1'b0;
    #0.5;
    expect_rd("R4 write during reset lost", 3'd0, 8'h00);
    expect_pins("R8 address after reset", 8'h65, 8'hFF, 8'hFF);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule